// File: doc/BRIEF.md
# Nested Two-Stage Address Translator

This block turns a guest virtual address into a host physical address in hardware, for a core that runs a guest operating system under a hypervisor. The guest owns a two-level page table that maps guest virtual pages to guest physical pages. The hypervisor owns a second two-level table that maps guest physical pages to host physical pages. The guest's root pointer and every frame number in a guest entry are guest physical addresses. The block therefore runs a complete host-table walk before each guest-table read, and one more walk for the final data page. A single translation with no fault takes three host walks and two guest reads, eight memory reads in all.

The block has one memory read port that takes host physical addresses, and it keeps at most one read outstanding. Software loads two frame-number inputs. The hypervisor sets the root of the host table. The guest sets the root of its own table, which is captured when a request is accepted. The result is either a host physical address, or a fault that says which stage failed and which address caused it. A guest-stage fault goes to the guest's own handler. A host-stage fault goes to the hypervisor.

Top module: `nested_xlat`

## Requirements
- R1: After reset, `reqReady` is 1 and both `respValid` and `memReqValid` are 0. While `reqReady` is 1, no memory read is issued.
- R2: `memReqValid` is a one-cycle pulse. A second read is never issued until `memRspValid` has returned the data for the previous read.
- R3: A host walk of guest physical address G first reads `{hostBase, G[31:22], 2'b00}`. It then reads `{F1, G[21:12], 2'b00}`, where F1 is the frame number from the first entry. G maps to `{F2, G[11:0]}`, where F2 is the frame number from the second entry.
- R4: The first guest entry has guest physical address `{guestBase, VA[31:22], 2'b00}`. The second guest entry has `{Fg1, VA[21:12], 2'b00}`, where Fg1 is the frame number from the first guest entry. The data page has `{Fg2, VA[11:0]}`. Each of these three addresses is host-walked, and each guest entry is read at its translated host physical address.
- R5: A translation with no fault makes exactly 8 reads. It returns `respFault=0` and `respPa = {final host frame, VA[11:0]}`.
- R6: Every entry is 32 bits: frame number in [31:12], present in bit 0, read in bit 1, write in bit 2, execute in bit 3. Bits [11:4] are ignored.
- R7: `reqAccess` encodes read as 0, write as 1 and execute as 2 or 3. The guest leaf entry and the host leaf entry for the data page must both grant the requested right.
- R8: Guest fault (`faultStage=0`, `faultAddr`=VA): the first guest entry is not present, or the guest leaf entry is not present or lacks the requested right.
- R9: Host fault (`faultStage=1`, `faultAddr` = the guest physical address being walked): any host entry is not present, the host leaf for a page that holds a guest table lacks read, or the host leaf for the data page lacks the requested right.
- R10: `respValid` is a one-cycle pulse. `reqReady` is 1 in the same cycle.
- R11: A walk stops at its first fault, and no further reads follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Idle, request accepted this cycle |
| reqVa | input | 32 | Guest virtual address |
| reqAccess | input | 2 | 0 read, 1 write, 2/3 execute |
| guestBase | input | 20 | Guest root table frame (guest physical) |
| hostBase | input | 20 | Host root table frame (host physical) |
| memReqValid | output | 1 | Memory read pulse |
| memAddr | output | 32 | Host physical read address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data (table entry) |
| respValid | output | 1 | Result pulse |
| respFault | output | 1 | Translation faulted |
| faultStage | output | 1 | 0 guest stage, 1 host stage |
| faultAddr | output | 32 | Faulting guest virtual or guest physical address |
| respPa | output | 32 | Host physical address |

## Verification
The bench builds the block with its default parameters: two 10-bit index levels, a 12-bit page offset and 32-bit entries. With these values the full 32-bit address space is in reach. The bench backs it with a sparse memory, which lets table pages, host tables and data pages sit at widely separated frames. A missing host root entry can then be hit at a high top-level index, well away from the populated index 0. The memory latency is varied between one and three cycles, which exercises the wait for each response.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    SEL_HOST_L1 = 2'd0,
    SEL_HOST_L2 = 2'd1,
    SEL_GUEST   = 2'd2
  } memSel_e;

  typedef struct packed {
    logic    loadReq;
    logic    latchNext;
    logic    gpaStep1;
    logic    gpaStep2;
    logic    finish;
    logic    faultGuest;
    logic    faultHost;
    memSel_e sel;
  } strobe_t;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqAccess,
  input  logic       memRspValid,
  input  logic       rspPresent,
  input  logic [2:0] rspPerm,
  output strobe_t    st,
  output logic       reqReady,
  output logic       memReqValid
);
  typedef enum logic [1:0] {S_IDLE, S_HL1, S_HL2, S_GRD} state_e;

  state_e     state, stateNext;
  logic [1:0] phase, phaseNext;
  logic [1:0] acc;
  logic       waiting;
  logic       gotRsp;
  logic       accOk;
  logic       hostLeafOk;

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state != S_IDLE) && !waiting;
  assign gotRsp      = waiting && memRspValid;

  always_comb begin
    case (acc)
      ACC_READ:  accOk = rspPerm[0];
      ACC_WRITE: accOk = rspPerm[1];
      default:   accOk = rspPerm[2];
    endcase
    hostLeafOk = (phase == 2'd2) ? accOk : rspPerm[0];
  end

  always_comb begin
    st        = '0;
    st.sel    = SEL_HOST_L1;
    stateNext = state;
    phaseNext = phase;
    case (state)
      S_IDLE: if (reqValid) begin
        st.loadReq = 1'b1;
        phaseNext  = 2'd0;
        stateNext  = S_HL1;
      end
      S_HL1: if (gotRsp) begin
        if (!rspPresent) begin
          st.faultHost = 1'b1;
          stateNext    = S_IDLE;
        end else begin
          st.latchNext = 1'b1;
          stateNext    = S_HL2;
        end
      end
      S_HL2: begin
        st.sel = SEL_HOST_L2;
        if (gotRsp) begin
          if (!rspPresent || !hostLeafOk) begin
            st.faultHost = 1'b1;
            stateNext    = S_IDLE;
          end else if (phase == 2'd2) begin
            st.finish = 1'b1;
            stateNext = S_IDLE;
          end else begin
            st.latchNext = 1'b1;
            stateNext    = S_GRD;
          end
        end
      end
      default: begin
        st.sel = SEL_GUEST;
        if (gotRsp) begin
          if (phase == 2'd0 && rspPresent) begin
            st.gpaStep1 = 1'b1;
            phaseNext   = 2'd1;
            stateNext   = S_HL1;
          end else if (phase == 2'd1 && rspPresent && accOk) begin
            st.gpaStep2 = 1'b1;
            phaseNext   = 2'd2;
            stateNext   = S_HL1;
          end else begin
            st.faultGuest = 1'b1;
            stateNext     = S_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= 2'd0;
      acc     <= 2'd0;
      waiting <= 1'b0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
      if (st.loadReq) acc <= reqAccess;
      if (memReqValid)  waiting <= 1'b1;
      else if (gotRsp)  waiting <= 1'b0;
    end
  end
endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32,
  localparam int PA_W    = 2 * IDX_W + OFF_W,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int ENT_SH  = OFF_W - IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [PA_W-1:0]    reqVa,
  input  logic [FRAME_W-1:0] guestBase,
  input  logic [FRAME_W-1:0] hostBase,
  input  logic [DATA_W-1:0]  memRspData,
  output logic [PA_W-1:0]    memAddr,
  output logic               rspPresent,
  output logic [2:0]         rspPerm,
  output logic               respValid,
  output logic               respFault,
  output logic               faultStage,
  output logic [PA_W-1:0]    faultAddr,
  output logic [PA_W-1:0]    respPa
);
  logic [PA_W-1:0]    vaReg;
  logic [PA_W-1:0]    gpa;
  logic [FRAME_W-1:0] nextFrame;
  logic [FRAME_W-1:0] rspFrame;
  logic               unusedRsvd;

  assign rspFrame   = memRspData[DATA_W-1 -: FRAME_W];
  assign rspPresent = memRspData[0];
  assign rspPerm    = memRspData[3:1];
  assign unusedRsvd = ^memRspData[DATA_W-FRAME_W-1:4];

  always_comb begin
    case (st.sel)
      SEL_HOST_L1: memAddr = {hostBase, gpa[PA_W-1 -: IDX_W], {ENT_SH{1'b0}}};
      SEL_HOST_L2: memAddr = {nextFrame, gpa[PA_W-IDX_W-1 -: IDX_W], {ENT_SH{1'b0}}};
      default:     memAddr = {nextFrame, gpa[OFF_W-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg      <= '0;
      gpa        <= '0;
      nextFrame  <= '0;
      respValid  <= 1'b0;
      respFault  <= 1'b0;
      faultStage <= 1'b0;
      faultAddr  <= '0;
      respPa     <= '0;
    end else begin
      respValid <= st.finish | st.faultGuest | st.faultHost;
      if (st.loadReq) begin
        vaReg <= reqVa;
        gpa   <= {guestBase, reqVa[PA_W-1 -: IDX_W], {ENT_SH{1'b0}}};
      end
      if (st.latchNext) nextFrame <= rspFrame;
      if (st.gpaStep1) gpa <= {rspFrame, vaReg[PA_W-IDX_W-1 -: IDX_W], {ENT_SH{1'b0}}};
      if (st.gpaStep2) gpa <= {rspFrame, vaReg[OFF_W-1:0]};
      if (st.finish) begin
        respFault <= 1'b0;
        respPa    <= {rspFrame, gpa[OFF_W-1:0]};
      end
      if (st.faultGuest) begin
        respFault  <= 1'b1;
        faultStage <= 1'b0;
        faultAddr  <= vaReg;
      end
      if (st.faultHost) begin
        respFault  <= 1'b1;
        faultStage <= 1'b1;
        faultAddr  <= gpa;
      end
    end
  end
endmodule

// File: rtl/nested_xlat.sv
module nested_xlat
  import xlat_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [2*IDX_W+OFF_W-1:0] reqVa,
  input  logic [1:0]               reqAccess,
  input  logic [2*IDX_W-1:0]       guestBase,
  input  logic [2*IDX_W-1:0]       hostBase,
  output logic                     memReqValid,
  output logic [2*IDX_W+OFF_W-1:0] memAddr,
  input  logic                     memRspValid,
  input  logic [DATA_W-1:0]        memRspData,
  output logic                     respValid,
  output logic                     respFault,
  output logic                     faultStage,
  output logic [2*IDX_W+OFF_W-1:0] faultAddr,
  output logic [2*IDX_W+OFF_W-1:0] respPa
);
  strobe_t    st;
  logic       rspPresent;
  logic [2:0] rspPerm;

  xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAccess(reqAccess),
    .memRspValid(memRspValid), .rspPresent(rspPresent), .rspPerm(rspPerm),
    .st(st), .reqReady(reqReady), .memReqValid(memReqValid)
  );

  xlat_datapath #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqVa(reqVa), .guestBase(guestBase),
    .hostBase(hostBase), .memRspData(memRspData), .memAddr(memAddr),
    .rspPresent(rspPresent), .rspPerm(rspPerm), .respValid(respValid),
    .respFault(respFault), .faultStage(faultStage), .faultAddr(faultAddr),
    .respPa(respPa)
  );
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [PA_W-1:0] reqVa,
  input logic            memReqValid,
  input logic            memRspValid,
  input logic            respValid,
  input logic            respFault,
  input logic            faultStage,
  input logic [PA_W-1:0] faultAddr,
  input logic [PA_W-1:0] respPa
);
  logic            outstanding;
  logic [3:0]      readCnt;
  logic [PA_W-1:0] vaHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= 1'b0;
      readCnt     <= '0;
      vaHeld      <= '0;
    end else begin
      if (memReqValid)      outstanding <= 1'b1;
      else if (memRspValid) outstanding <= 1'b0;
      if (reqValid && reqReady) begin
        readCnt <= '0;
        vaHeld  <= reqVa;
      end else if (memReqValid) begin
        readCnt <= readCnt + 4'd1;
      end
    end
  end

  p_one_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !outstanding);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid);
  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);
  p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFault) |-> respPa[OFF_W-1:0] == vaHeld[OFF_W-1:0]);
  p_eight_reads_r5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFault) |-> readCnt == 4'd8);
  p_guest_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault && !faultStage) |-> faultAddr == vaHeld);
endmodule

bind nested_xlat xlat_checker #(.PA_W(2*IDX_W+OFF_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqVa(reqVa), .memReqValid(memReqValid), .memRspValid(memRspValid),
  .respValid(respValid), .respFault(respFault), .faultStage(faultStage),
  .faultAddr(faultAddr), .respPa(respPa)
);

// File: tb/nested_xlat_bench.sv
module nested_xlat_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVa = '0;
  logic [1:0]  reqAccess = '0;
  logic [19:0] guestBase = 20'h00010;
  logic [19:0] hostBase  = 20'h00100;
  logic        memReqValid;
  logic [31:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        respValid, respFault, faultStage;
  logic [31:0] faultAddr, respPa;

  int checks = 0, failures = 0, cycles = 0;
  int lat = 1, pend = 0, reads = 0;
  logic [31:0] pendAddr;
  logic [31:0] addrLog [0:15];
  logic [31:0] mem [logic [29:0]];
  logic gotFault, gotStage;
  logic [31:0] gotAddr, gotPa;

  always #2 clk = ~clk;

  nested_xlat u_nested_xlat (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .reqAccess(reqAccess), .guestBase(guestBase),
    .hostBase(hostBase), .memReqValid(memReqValid), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .respValid(respValid),
    .respFault(respFault), .faultStage(faultStage), .faultAddr(faultAddr),
    .respPa(respPa)
  );

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    memRspValid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        memRspValid = 1'b1;
        memRspData  = mem.exists(pendAddr[31:2]) ? mem[pendAddr[31:2]] : 32'h0;
      end
    end
    if (memReqValid) begin
      checks++;
      if (pend != 0) begin
        failures++;
        $display("FAIL R2 actual=second read expected=none outstanding");
      end
      pendAddr = memAddr;
      pend = lat;
      if (reads < 16) addrLog[reads] = memAddr;
      reads++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void wr(input logic [31:0] a, input logic [31:0] v);
    mem[a[31:2]] = v;
  endfunction

  function automatic logic [31:0] ent(input logic [19:0] f, input logic [2:0] perm);
    return {f, 8'h00, perm, 1'b1};
  endfunction

  function automatic void hostMap(input logic [19:0] gf, input logic [19:0] hf, input logic [2:0] perm);
    logic [19:0] l2f = 20'h00200 + {10'h0, gf[19:10]};
    wr({hostBase, gf[19:10], 2'b00}, ent(l2f, 3'b000));
    wr({l2f, gf[9:0], 2'b00}, ent(hf, perm));
  endfunction

  function automatic void gWrite(input logic [31:0] gpa, input logic [31:0] v);
    hostMap(gpa[31:12], gpa[31:12] ^ 20'h80000, 3'b111);
    wr({gpa[31:12] ^ 20'h80000, gpa[11:0]}, v);
  endfunction

  function automatic logic [31:0] mkVa(input int i1, input int i2, input int off);
    return (i1 << 22) | (i2 << 12) | off;
  endfunction

  task automatic doReq(input logic [31:0] va, input logic [1:0] acc, input int l, input string tag);
    int n = 0;
    lat = l;
    while (!reqReady) @(negedge clk);
    reads = 0;
    reqVa = va; reqAccess = acc; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!respValid && n < 300) begin @(negedge clk); n++; end
    chk(respValid, {tag, " R10 response seen"}, {31'h0, respValid}, 32'h1);
    chk(reqReady, {tag, " R10 ready with response"}, {31'h0, reqReady}, 32'h1);
    gotFault = respFault; gotStage = faultStage; gotAddr = faultAddr; gotPa = respPa;
    @(negedge clk);
    chk(!respValid, {tag, " R10 single pulse"}, {31'h0, respValid}, 32'h0);
    repeat (4) @(negedge clk);
  endtask

  task automatic expectOk(input string tag, input logic [31:0] pa, input int nReads);
    chk(!gotFault, {tag, " R5 no fault"}, {31'h0, gotFault}, 32'h0);
    chk(gotPa == pa, {tag, " R5 physical address"}, gotPa, pa);
    chk(reads == nReads, {tag, " R5 read count"}, reads, nReads);
  endtask

  task automatic expectFault(input string tag, input logic stg, input logic [31:0] a, input int nReads);
    chk(gotFault, {tag, " fault flag"}, {31'h0, gotFault}, 32'h1);
    chk(gotStage == stg, {tag, " fault stage"}, {31'h0, gotStage}, {31'h0, stg});
    chk(gotAddr == a, {tag, " fault address"}, gotAddr, a);
    chk(reads == nReads, {tag, " R11 reads stop at fault"}, reads, nReads);
  endtask

  task automatic testReset();
    chk(reqReady, "R1 ready after reset", {31'h0, reqReady}, 32'h1);
    chk(!respValid, "R1 no response after reset", {31'h0, respValid}, 32'h0);
    chk(!memReqValid, "R1 no read after reset", {31'h0, memReqValid}, 32'h0);
  endtask

  task automatic testWalkOrder();
    doReq(mkVa(1, 3, 12'hABC), 2'd0, 1, "T1");
    expectOk("T1", 32'h80300ABC, 8);
    chk(addrLog[0] == 32'h00100000, "R3 host root read", addrLog[0], 32'h00100000);
    chk(addrLog[1] == 32'h00200040, "R3 host leaf read", addrLog[1], 32'h00200040);
    chk(addrLog[2] == 32'h80010004, "R4 guest root entry", addrLog[2], 32'h80010004);
    chk(addrLog[5] == 32'h8002000C, "R4 guest leaf entry", addrLog[5], 32'h8002000C);
    chk(addrLog[7] == 32'h00200C00, "R4 data page host walk", addrLog[7], 32'h00200C00);
  endtask

  task automatic testSlowWrite();
    doReq(mkVa(1, 3, 12'hABC), 2'd1, 3, "T2 R7 write");
    expectOk("T2 R7 write", 32'h80300ABC, 8);
  endtask

  task automatic testGuestFaults();
    doReq(mkVa(5, 0, 12'h010), 2'd0, 2, "T3 R8 root absent");
    expectFault("T3 R8 root absent", 1'b0, mkVa(5, 0, 12'h010), 3);
    doReq(mkVa(1, 4, 12'h020), 2'd1, 1, "T4 R8 R6 no write");
    expectFault("T4 R8 R6 no write", 1'b0, mkVa(1, 4, 12'h020), 6);
    doReq(mkVa(1, 4, 12'h020), 2'd0, 1, "T4b R6 read allowed");
    expectOk("T4b R6 read allowed", 32'h80301020, 8);
    doReq(mkVa(1, 6, 12'h044), 2'd0, 1, "T5b R7 guest X only");
    expectFault("T5b R7 guest X only", 1'b0, mkVa(1, 6, 12'h044), 6);
  endtask

  task automatic testHostFaults();
    doReq(mkVa(1, 6, 12'h044), 2'd2, 1, "T5 R9 host lacks X");
    expectFault("T5 R9 host lacks X", 1'b1, 32'h00302044, 8);
    doReq(mkVa(2, 1, 12'h000), 2'd0, 2, "T6 R9 table unmapped");
    expectFault("T6 R9 table unmapped", 1'b1, 32'h00021004, 5);
    doReq(mkVa(1, 7, 12'h008), 2'd0, 1, "T7 R9 host root absent");
    expectFault("T7 R9 host root absent", 1'b1, 32'h40000008, 7);
    doReq(mkVa(3, 2, 12'h000), 2'd0, 1, "T8 R9 table no read");
    expectFault("T8 R9 table no read", 1'b1, 32'h00022008, 5);
  endtask

  initial begin
    gWrite({20'h00010, 10'd1, 2'b00}, ent(20'h00020, 3'b000));
    gWrite({20'h00010, 10'd2, 2'b00}, ent(20'h00021, 3'b000));
    gWrite({20'h00010, 10'd3, 2'b00}, ent(20'h00022, 3'b000));
    gWrite({20'h00020, 10'd3, 2'b00}, ent(20'h00300, 3'b011));
    gWrite({20'h00020, 10'd4, 2'b00}, ent(20'h00301, 3'b001) | 32'h00000FF0);
    gWrite({20'h00020, 10'd6, 2'b00}, ent(20'h00302, 3'b100));
    gWrite({20'h00020, 10'd7, 2'b00}, ent(20'h40000, 3'b111));
    hostMap(20'h00300, 20'h80300, 3'b111);
    hostMap(20'h00301, 20'h80301, 3'b111);
    hostMap(20'h00302, 20'h80302, 3'b011);
    hostMap(20'h00022, 20'h80022, 3'b010);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWalkOrder();
    testSlowWrite();
    testGuestFaults();
    testHostFaults();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule